// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block turns a short command request into the full sequence of bus cycles that a parallel NOR flash with an on-chip controller expects. The user puts a 4-bit command code, a target address and a data word on the inputs and pulses `start`. The sequencer then issues between two and six bus writes to the device's command registers. Each write has its address and data chosen from the command and the index of the write. After the writes it issues either one read, whose result is returned, or a series of status reads that wait for an embedded program or erase algorithm to finish.

Every bus access holds its strobe low for a fixed number of system clocks. Read accesses and write accesses have separate parameters for this. One idle cycle with all strobes high follows each access. Polling compares status bit 7 with the bit 7 the finished operation should leave behind. A set bit 5 (the device's time-limit flag) on a mismatch allows exactly one confirming read. A parameter caps the total number of polls. Completion is a one-cycle `done` pulse with `err` valid beside it.

Top module: `flash_cmd_seq`

## Requirements
- R1: While reset is held and after its release with no command, `f_ce_n`, `f_oe_n` and `f_we_n` are 1 and `busy` and `done` are 0.
- R2: A `start` sampled high while the block is idle is accepted, and the block captures `cmd`, `addr` and `wdata` at that edge. A `start` arriving while `busy` is 1 has no effect: the running bus sequence, its result and its single `done` are unchanged.
- R3: Supported codes and their bus writes, listed as address/data pairs. U1 is 0x555 and U2 is 0x2AA, the unlock addresses for a 16-bit bus; an 8-bit bus uses 0xAAA and 0x555. A is the captured address and D the captured data.
  - 0x1 read: U1/F0, A/F0.
  - 0x2 identify: U1/AA, U2/55, U1/90.
  - 0x3 program: U1/AA, U2/55, U1/A0, A/D.
  - 0x4 sector erase: U1/AA, U2/55, U1/80, U1/AA, U2/55, A/30.
  - 0x5 chip erase: the same as 0x4, with U1/10 as the last write.
- R4: The number of write cycles issued for a command is exactly the count implied by R3 (2, 3, 4 or 6).
- R5: Each write holds `f_we_n` and `f_ce_n` low for exactly WR_LAT clocks with `f_addr` and the driven data stable. At least one cycle with all strobes high follows it, and `f_we_n` and `f_oe_n` are never low together.
- R6: Each read holds `f_oe_n` and `f_ce_n` low for exactly RD_LAT clocks at address A with the data bus released. The value on `f_dq` in the last clock of that window is captured into `rd_data`.
- R7: Codes 0x1 and 0x2 end after one read at A, with `err` 0 and `rd_data` equal to the word read.
- R8: Codes 0x3 to 0x5 poll A. A read ends the command with `err` 0 when its bit 7 equals the expected bit: D[7] for program, 1 for either erase.
- R9: A polling read whose bit 7 mismatches and whose bit 5 is 1 is followed by exactly one more read. If that read also mismatches, the command ends with `err` 1.
- R10: If POLL_MAX polling reads all mismatch with bit 5 clear, the command ends with `err` 1 after exactly POLL_MAX reads.
- R11: Any other code produces no bus access and ends with `done` and `err` 1 one cycle after acceptance.
- R12: `done` is a single-cycle pulse, and `busy` falls in the cycle after it. `busy` is high for n·(WR_LAT+1) + r·(RD_LAT+1) + 1 cycles, where n is the number of writes and r the number of reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch request, taken while idle |
| cmd | input | 4 | Command code |
| addr | input | ADDR_W | Target flash address |
| wdata | input | DATA_W | Program data |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Failure flag, valid with `done` |
| rd_data | output | DATA_W | Last word read from the flash |
| f_addr | output | ADDR_W | Flash address bus |
| f_dq | inout | DATA_W | Flash data bus, driven only during writes |
| f_ce_n | output | 1 | Chip enable, active low |
| f_oe_n | output | 1 | Output enable, active low |
| f_we_n | output | 1 | Write enable, active low |

## Verification
The assertions assume that the flash model releases `f_dq` whenever `f_oe_n` is high. They also assume `start` is a pulse and that `cmd`, `addr` and `wdata` are valid in the cycle it is sampled. The bench's flash model drives the bus only through a tri-state gated on `f_oe_n`. Its status value is held constant for the whole read window and changes only after `f_oe_n` rises. The random stimulus draws codes from both the supported and the unsupported sets. It also draws busy-read counts and the bit-5 behaviour, and it never changes the inputs other than at a falling edge.

// File: rtl/fcs_pkg.sv
// Package: shared types for the flash command sequencer.
// Holds command codes, the tail kind after the writes, the FSM states
// and a decode function giving the write count for a command code.
package fcs_pkg;

    localparam logic [3:0] OP_READ   = 4'h1;
    localparam logic [3:0] OP_IDENT  = 4'h2;
    localparam logic [3:0] OP_PROG   = 4'h3;
    localparam logic [3:0] OP_SERASE = 4'h4;
    localparam logic [3:0] OP_CERASE = 4'h5;

    typedef enum logic [1:0] {
        TAIL_NONE,
        TAIL_READ,
        TAIL_POLL
    } tail_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WSTB,
        S_WGAP,
        S_RSTB,
        S_RGAP,
        S_FIN
    } state_e;

    typedef struct packed {
        logic       valid;
        logic [2:0] nwr;
        tail_e      tail;
        logic       erase;
    } cmd_info_t;

    // Classify a command code: support, write count, tail kind, erase flag.
    function automatic cmd_info_t cmd_info(input logic [3:0] c);
        cmd_info_t i;
        i = '{valid: 1'b0, nwr: 3'd0, tail: TAIL_NONE, erase: 1'b0};
        case (c)
            OP_READ:   i = '{valid: 1'b1, nwr: 3'd2, tail: TAIL_READ, erase: 1'b0};
            OP_IDENT:  i = '{valid: 1'b1, nwr: 3'd3, tail: TAIL_READ, erase: 1'b0};
            OP_PROG:   i = '{valid: 1'b1, nwr: 3'd4, tail: TAIL_POLL, erase: 1'b0};
            OP_SERASE: i = '{valid: 1'b1, nwr: 3'd6, tail: TAIL_POLL, erase: 1'b1};
            OP_CERASE: i = '{valid: 1'b1, nwr: 3'd6, tail: TAIL_POLL, erase: 1'b1};
            default:   i = '{valid: 1'b0, nwr: 3'd0, tail: TAIL_NONE, erase: 1'b0};
        endcase
        return i;
    endfunction

endpackage

// File: rtl/fcs_timer.sv
// Module: down-counting access latency timer.
// A load sets the count to the given value; it then counts down to zero.
// `last` is high in the final cycle of a window of `value` cycles.
// Assumes value >= 1 and value <= MAXV.
module fcs_timer #(
    parameter int MAXV = 300,
    localparam int TW  = $clog2(MAXV + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] value,
    output logic          last
);

    logic [TW-1:0] cnt;

    // Count register: load on request, otherwise decrement toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= value;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign last = (cnt == TW'(1));

    // R5 / R6: the window count never exceeds the configured maximum.
    a_r5_timer_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= TW'(MAXV));

endmodule

// File: rtl/fcs_decode.sv
// Module: address/data selection for each write cycle.
// From the captured command code and the write index, produces the
// address and data of that bus write. Unlock addresses depend on the
// data width: a byte-wide bus uses doubled addresses.
// Assumes ADDR_W >= 12.
module fcs_decode
    import fcs_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic [3:0]        op,
    input  logic [2:0]        idx,
    input  logic [ADDR_W-1:0] user_addr,
    input  logic [DATA_W-1:0] user_data,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_data
);

    localparam logic [ADDR_W-1:0] UA1 = (DATA_W == 16) ? ADDR_W'(12'h555) : ADDR_W'(12'hAAA);
    localparam logic [ADDR_W-1:0] UA2 = (DATA_W == 16) ? ADDR_W'(12'h2AA) : ADDR_W'(12'h555);

    // Select the pair for the current write from command and index.
    always_comb begin
        bus_addr = UA1;
        bus_data = DATA_W'(8'hAA);
        case (idx)
            3'd0: begin
                if (op == OP_READ) bus_data = DATA_W'(8'hF0);
            end
            3'd1: begin
                if (op == OP_READ) begin
                    bus_addr = user_addr;
                    bus_data = DATA_W'(8'hF0);
                end else begin
                    bus_addr = UA2;
                    bus_data = DATA_W'(8'h55);
                end
            end
            3'd2: begin
                if (op == OP_IDENT)     bus_data = DATA_W'(8'h90);
                else if (op == OP_PROG) bus_data = DATA_W'(8'hA0);
                else                    bus_data = DATA_W'(8'h80);
            end
            3'd3: begin
                if (op == OP_PROG) begin
                    bus_addr = user_addr;
                    bus_data = user_data;
                end
            end
            3'd4: begin
                bus_addr = UA2;
                bus_data = DATA_W'(8'h55);
            end
            3'd5: begin
                if (op == OP_SERASE) begin
                    bus_addr = user_addr;
                    bus_data = DATA_W'(8'h30);
                end else begin
                    bus_data = DATA_W'(8'h10);
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/flash_cmd_seq.sv
// Module: NOR flash command sequencer (top).
// Accepts a command on a start pulse while idle, issues the command's
// bus writes, then one read or a status-polling loop, and pulses done.
// Assumes the flash releases f_dq while f_oe_n is high, and that
// WR_LAT, RD_LAT and POLL_MAX are at least 1.
module flash_cmd_seq
    import fcs_pkg::*;
#(
    parameter int ADDR_W   = 20,
    parameter int DATA_W   = 16,
    parameter int WR_LAT   = 250,
    parameter int RD_LAT   = 180,
    parameter int POLL_MAX = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [3:0]        cmd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] f_addr,
    inout  wire  [DATA_W-1:0] f_dq,
    output logic              f_ce_n,
    output logic              f_oe_n,
    output logic              f_we_n
);

    localparam int LAT_MAX = (WR_LAT > RD_LAT) ? WR_LAT : RD_LAT;
    localparam int TW      = $clog2(LAT_MAX + 1);
    localparam int PW      = $clog2(POLL_MAX + 1);

    state_e            st;
    logic [3:0]        cmd_q;
    tail_e             tail_q;
    logic              erase_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wd_q;
    logic [DATA_W-1:0] rd_q;
    logic [2:0]        wcnt;
    logic [2:0]        widx;
    logic [PW-1:0]     pcnt;
    logic              recheck;
    logic              err_q;

    cmd_info_t         inf_in;
    logic              accept;
    logic              wr_load, rd_load, wr_last, rd_last;
    logic              tgt7, match, poll_again;
    logic [ADDR_W-1:0] seq_addr;
    logic [DATA_W-1:0] seq_data;

    assign inf_in = cmd_info(cmd);
    assign accept = (st == S_IDLE) && start;

    // Polling decision: expected bit 7, match test and whether to read again.
    always_comb begin
        tgt7       = erase_q ? 1'b1 : wd_q[7];
        match      = (rd_q[7] == tgt7);
        poll_again = (st == S_RGAP) && (tail_q == TAIL_POLL) && !match && !recheck
                     && (rd_q[5] || (pcnt != PW'(POLL_MAX - 1)));
    end

    assign wr_load = (accept && inf_in.valid) || ((st == S_WGAP) && (wcnt != 3'd0));
    assign rd_load = ((st == S_WGAP) && (wcnt == 3'd0)) || poll_again;

    fcs_timer #(.MAXV(LAT_MAX)) u_wr_timer (
        .clk(clk), .rst_n(rst_n), .load(wr_load), .value(TW'(WR_LAT)), .last(wr_last)
    );

    fcs_timer #(.MAXV(LAT_MAX)) u_rd_timer (
        .clk(clk), .rst_n(rst_n), .load(rd_load), .value(TW'(RD_LAT)), .last(rd_last)
    );

    fcs_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_decode (
        .op(cmd_q), .idx(widx), .user_addr(addr_q), .user_data(wd_q),
        .bus_addr(seq_addr), .bus_data(seq_data)
    );

    // Main sequencer: capture, write loop, read/poll loop, completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= S_IDLE;
            cmd_q   <= '0;
            tail_q  <= TAIL_NONE;
            erase_q <= 1'b0;
            addr_q  <= '0;
            wd_q    <= '0;
            rd_q    <= '0;
            wcnt    <= '0;
            widx    <= '0;
            pcnt    <= '0;
            recheck <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            case (st)
                S_IDLE: begin
                    if (start) begin
                        cmd_q   <= cmd;
                        tail_q  <= inf_in.tail;
                        erase_q <= inf_in.erase;
                        addr_q  <= addr;
                        wd_q    <= wdata;
                        wcnt    <= inf_in.nwr;
                        widx    <= '0;
                        pcnt    <= '0;
                        recheck <= 1'b0;
                        err_q   <= !inf_in.valid;
                        st      <= inf_in.valid ? S_WSTB : S_FIN;
                    end
                end
                S_WSTB: begin
                    if (wr_last) begin
                        wcnt <= wcnt - 3'd1;
                        widx <= widx + 3'd1;
                        st   <= S_WGAP;
                    end
                end
                S_WGAP: st <= (wcnt != 3'd0) ? S_WSTB : S_RSTB;
                S_RSTB: begin
                    if (rd_last) begin
                        rd_q <= f_dq;
                        st   <= S_RGAP;
                    end
                end
                S_RGAP: begin
                    if (poll_again) begin
                        pcnt    <= pcnt + 1'b1;
                        recheck <= rd_q[5];
                        st      <= S_RSTB;
                    end else begin
                        err_q <= (tail_q == TAIL_POLL) && !match;
                        st    <= S_FIN;
                    end
                end
                S_FIN:   st <= S_IDLE;
                default: st <= S_IDLE;
            endcase
        end
    end

    // Port drive: strobes by state, address by phase, data only in writes.
    assign f_ce_n  = !((st == S_WSTB) || (st == S_RSTB));
    assign f_we_n  = !(st == S_WSTB);
    assign f_oe_n  = !(st == S_RSTB);
    assign f_addr  = ((st == S_WSTB) || (st == S_WGAP)) ? seq_addr : addr_q;
    assign f_dq    = (st == S_WSTB) ? seq_data : {DATA_W{1'bz}};
    assign busy    = (st != S_IDLE);
    assign done    = (st == S_FIN);
    assign err     = err_q;
    assign rd_data = rd_q;

    // R5: address and write data hold still across a write window.
    a_r5_write_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!f_we_n && $past(!f_we_n)) |-> ($stable(f_addr) && $stable(seq_data)));

    // R5: write and read strobes never overlap, and each implies chip enable.
    a_r5_strobes: assert property (@(posedge clk) disable iff (!rst_n)
        !(!f_we_n && !f_oe_n) && ((!f_we_n || !f_oe_n) -> !f_ce_n));

    // R2: captured command cannot change while busy.
    a_r2_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(cmd_q));

    // R12: done is followed by idle.
    a_r12_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!busy && !done));

    // R4: write count never exceeds six.
    a_r4_wcnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        wcnt <= 3'd6);

    // R10: poll count stays within its bound.
    a_r10_poll_bound: assert property (@(posedge clk) disable iff (!rst_n)
        pcnt <= PW'(POLL_MAX));

endmodule

// File: tb/sim_flash_cmd_seq.sv
// Bench: flash model plus directed and seeded random commands.
module sim_flash_cmd_seq;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 20;
    localparam int DATA_W     = 16;
    localparam int WR_LAT     = 4;
    localparam int RD_LAT     = 3;
    localparam int POLL_MAX   = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [3:0]        cmd = '0;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] wdata = '0;
    logic              busy, done, err;
    logic [DATA_W-1:0] rd_data;
    logic [ADDR_W-1:0] f_addr;
    wire  [DATA_W-1:0] f_dq;
    logic              f_ce_n, f_oe_n, f_we_n;

    int checks = 0;
    int errors = 0;

    // flash model state
    logic [DATA_W-1:0] fm_final = '0;
    int                fm_busy_left = 0;
    logic              fm_dq5 = 1'b0;
    logic [DATA_W-1:0] fm_val;

    assign fm_val = (fm_busy_left > 0)
                    ? (((fm_final ^ 16'h0080) & ~16'h0020) | (fm_dq5 ? 16'h0020 : 16'h0000))
                    : fm_final;
    assign f_dq = !f_oe_n ? fm_val : {DATA_W{1'bz}};

    always #(CLK_PERIOD / 2) clk = ~clk;

    flash_cmd_seq #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WR_LAT(WR_LAT),
        .RD_LAT(RD_LAT), .POLL_MAX(POLL_MAX)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .addr(addr),
        .wdata(wdata), .busy(busy), .done(done), .err(err), .rd_data(rd_data),
        .f_addr(f_addr), .f_dq(f_dq), .f_ce_n(f_ce_n), .f_oe_n(f_oe_n), .f_we_n(f_we_n)
    );

    // monitor records
    logic [ADDR_W-1:0] log_a [8];
    logic [DATA_W-1:0] log_d [8];
    int   nwr_seen, nrd_seen, busy_cyc, done_cnt, we_run, oe_run;
    logic win_bad, err_at_done;
    logic [ADDR_W-1:0] win_addr;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Bus monitor sampled just after each rising edge.
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            if ((!f_we_n || !f_oe_n) && f_ce_n) win_bad = 1'b1;
            if (!f_we_n && !f_oe_n) win_bad = 1'b1;
            if (!f_we_n) begin
                if (we_run == 0) begin
                    if (nwr_seen < 8) begin
                        log_a[nwr_seen] = f_addr;
                        log_d[nwr_seen] = f_dq;
                    end
                    win_addr = f_addr;
                end else if (f_addr != win_addr) win_bad = 1'b1;
                we_run++;
            end else if (we_run != 0) begin
                if (we_run != WR_LAT) win_bad = 1'b1;
                nwr_seen++;
                we_run = 0;
            end
            if (!f_oe_n) begin
                if (oe_run == 0) win_addr = f_addr;
                else if (f_addr != win_addr) win_bad = 1'b1;
                oe_run++;
            end else if (oe_run != 0) begin
                if (oe_run != RD_LAT) win_bad = 1'b1;
                nrd_seen++;
                oe_run = 0;
                if (fm_busy_left > 0) fm_busy_left--;
            end
            if (busy) busy_cyc++;
            if (done) begin
                done_cnt++;
                err_at_done = err;
            end
        end
    end

    function automatic bit is_valid(input logic [3:0] c);
        return (c >= 4'h1) && (c <= 4'h5);
    endfunction

    function automatic int exp_n(input logic [3:0] c);
        case (c)
            4'h1: return 2;
            4'h2: return 3;
            4'h3: return 4;
            4'h4, 4'h5: return 6;
            default: return 0;
        endcase
    endfunction

    function automatic logic [ADDR_W-1:0] exp_a(input logic [3:0] c, input int i, input logic [ADDR_W-1:0] a);
        if (c == 4'h1) return (i == 0) ? ADDR_W'(12'h555) : a;
        if ((c == 4'h3 && i == 3) || (c == 4'h4 && i == 5)) return a;
        if (i == 1 || i == 4) return ADDR_W'(12'h2AA);
        return ADDR_W'(12'h555);
    endfunction

    function automatic logic [DATA_W-1:0] exp_d(input logic [3:0] c, input int i, input logic [DATA_W-1:0] d);
        if (c == 4'h1) return 16'h00F0;
        case (i)
            0, 3: return (c == 4'h3 && i == 3) ? d : 16'h00AA;
            1, 4: return 16'h0055;
            2: return (c == 4'h2) ? 16'h0090 : (c == 4'h3) ? 16'h00A0 : 16'h0080;
            default: return (c == 4'h4) ? 16'h0030 : 16'h0010;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] pat(input logic [ADDR_W-1:0] a);
        return a[15:0] ^ 16'h5A3C;
    endfunction

    // Expected read count and error from the polling rules.
    task automatic exp_poll(input logic [3:0] c, input int busy_reads, input bit dq5,
                            output int reads, output bit e);
        bit rc;
        rc = 1'b0;
        reads = 0;
        e = 1'b0;
        if (!is_valid(c)) begin
            e = 1'b1;
            return;
        end
        if (c == 4'h1 || c == 4'h2) begin
            reads = 1;
            return;
        end
        forever begin
            reads++;
            if (reads > busy_reads) return;
            if (rc) begin e = 1'b1; return; end
            if (dq5) begin rc = 1'b1; continue; end
            if (reads == POLL_MAX) begin e = 1'b1; return; end
        end
    endtask

    task automatic run_cmd(input logic [3:0] c, input logic [ADDR_W-1:0] a,
                           input logic [DATA_W-1:0] d, input int busy_reads,
                           input bit dq5, input bit inject);
        int reads, n, wait_cyc;
        bit e;
        n = exp_n(c);
        exp_poll(c, busy_reads, dq5, reads, e);
        fm_final = (c == 4'h1 || c == 4'h2) ? pat(a) : (c == 4'h3) ? d : 16'hFFFF;
        fm_busy_left = (c >= 4'h3 && c <= 4'h5) ? busy_reads : 0;
        fm_dq5 = dq5;
        nwr_seen = 0; nrd_seen = 0; busy_cyc = 0; done_cnt = 0;
        we_run = 0; oe_run = 0; win_bad = 1'b0; err_at_done = 1'b0;
        @(negedge clk);
        cmd = c; addr = a; wdata = d; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (inject) begin
            repeat (5) @(negedge clk);
            cmd = 4'h3; addr = ~a; wdata = ~d; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        wait_cyc = 0;
        while (done_cnt == 0 && wait_cyc < 2000) begin
            @(negedge clk);
            wait_cyc++;
        end
        repeat (3) @(negedge clk);
        chk(done_cnt == 1, "R12 single done", done_cnt, 1);
        chk(nwr_seen == n, "R4 write count", nwr_seen, n);
        for (int i = 0; i < n && i < nwr_seen && i < 8; i++) begin
            chk(log_a[i] == exp_a(c, i, a), "R3 write address", log_a[i], exp_a(c, i, a));
            chk(log_d[i] == exp_d(c, i, d), "R3 write data", log_d[i], exp_d(c, i, d));
        end
        chk(!win_bad, "R5/R6 window timing", win_bad, 0);
        chk(nrd_seen == reads, "R8 read count", nrd_seen, reads);
        chk(err_at_done == e, "R9/R10/R11 err", err_at_done, e);
        chk(busy_cyc == n * (WR_LAT + 1) + reads * (RD_LAT + 1) + 1, "R12 busy length",
            busy_cyc, n * (WR_LAT + 1) + reads * (RD_LAT + 1) + 1);
        if (c == 4'h1 || c == 4'h2 || (is_valid(c) && !e))
            chk(rd_data == fm_final, "R7 rd_data", rd_data, fm_final);
        if (inject) chk(!busy, "R2 ignored start left idle", busy, 0);
    endtask

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd2718);
        repeat (3) @(negedge clk);
        chk(f_ce_n && f_oe_n && f_we_n, "R1 strobes in reset", {f_ce_n, f_oe_n, f_we_n}, 3'b111);
        chk(!busy && !done, "R1 idle in reset", {busy, done}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(f_ce_n && f_oe_n && f_we_n && !busy && !done, "R1 idle after reset",
            {f_ce_n, f_oe_n, f_we_n, busy, done}, 5'b11100);

        // directed cases
        run_cmd(4'h1, 20'h1_2345, 16'h0000, 0, 1'b0, 1'b0);  // R7 read
        run_cmd(4'h2, 20'h0_0001, 16'h0000, 0, 1'b0, 1'b0);  // R7 identify
        run_cmd(4'h3, 20'h4_0010, 16'h1234, 2, 1'b0, 1'b0);  // R8 program
        run_cmd(4'h3, 20'h4_0011, 16'h00C3, 0, 1'b0, 1'b0);  // R8 program, bit7 set
        run_cmd(4'h4, 20'h8_0000, 16'h0000, 3, 1'b0, 1'b0);  // R8 sector erase
        run_cmd(4'h5, 20'h0_0000, 16'h0000, 1, 1'b0, 1'b0);  // R8 chip erase
        run_cmd(4'h3, 20'h0_0100, 16'h00FF, 1, 1'b1, 1'b0);  // R9 recheck succeeds
        run_cmd(4'h4, 20'h0_0200, 16'h0000, 3, 1'b1, 1'b0);  // R9 recheck fails
        run_cmd(4'h3, 20'h0_0300, 16'h0055, 10, 1'b0, 1'b0); // R10 poll limit
        run_cmd(4'h3, 20'h0_0301, 16'h0055, POLL_MAX - 1, 1'b0, 1'b0); // R10 edge
        run_cmd(4'h0, 20'h0_0000, 16'h0000, 0, 1'b0, 1'b0);  // R11 unsupported
        run_cmd(4'hF, 20'hF_FFFF, 16'hFFFF, 0, 1'b0, 1'b0);  // R11 unsupported
        run_cmd(4'h1, 20'h3_0303, 16'h0000, 0, 1'b0, 1'b1);  // R2 start while busy

        // seeded random commands
        for (int k = 0; k < 40; k++) begin
            logic [3:0] rc;
            rc = ($urandom % 8 == 0) ? 4'(6 + $urandom % 10) : 4'(1 + $urandom % 5);
            run_cmd(rc, ADDR_W'($urandom), DATA_W'($urandom), int'($urandom % 8),
                    1'($urandom % 3 == 0), 1'($urandom % 6 == 0));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule